// File: doc/BRIEF.md
# Quadrature Input Glitch Filter

This block sits between two raw quadrature sense lines and a pulse counter running in an oversampled mode. Both lines are first brought into the sample-clock domain through two flip-flops. A per-line stability filter then accepts a new level only after it has been seen on a programmable number of consecutive sample edges. The window length is a small code plus five, so the default code of zero gives a five-sample window.

A second, optional stage removes flutter. When it is on, an output transition is withheld if the same output was also the last one to change. On a quadrature pair that pattern means a line is reversing with no move of the other line in between, so there is no net motion. The withheld level is released on the edge after the other line next changes. With both stages off, the block is a plain synchroniser with a fixed four-register latency.

Top module: `quad_glitch_filter`

## Requirements
- R1: While reset is asserted, both outputs are 0 and no output has yet been recorded as the most recent to change.
- R2: With the filter disabled and flutter removal off, a raw level first sampled at clock edge k appears on its output after edge k+3.
- R3: With the filter enabled, a raw level first sampled at edge k and then held appears on its output after edge k+L+2, where L = len_code + 5, and not one edge earlier.
- R4: With the filter enabled, an excursion of a raw input that lasts L-1 sample edges never reaches the output.
- R5: The stability count restarts whenever the synchronised input returns to the accepted level, even for a single edge. Two L-1 excursions separated by one edge are therefore both rejected.
- R6: The length code is LEN_W bits wide (3 by default). Code 0 gives a 5-edge window and the all-ones code (7) gives a 12-edge window.
- R7: With flutter removal on, a transition on an output is withheld while that same output was the last of the two outputs to change. The output holds its previous level.
- R8: A level withheld under R7 appears on the edge after the other output changes. In that edge only the other output moves.
- R9: With flutter removal on, strictly alternating transitions on the two inputs all pass with the R2 latency.
- R10: With flutter removal off, back-to-back reversals on the same input all reach the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s0_raw | input | 1 | Raw first quadrature line |
| s1_raw | input | 1 | Raw second quadrature line |
| filt_en | input | 1 | Enables the stability filter |
| len_code | input | LEN_W | Filter window code, window = code + 5 samples |
| flutter_en | input | 1 | Enables flutter removal |
| s0_out | output | 1 | Filtered first line |
| s1_out | output | 1 | Filtered second line |

## Verification
The bench measures the exact edge at which an accepted level appears, for both the shortest and the longest window. A counter that is off by one would show the level one cycle early or one cycle late. It sends pulses one sample shorter than the window, and two such pulses split by a single-cycle return. A filter that accepts short pulses or fails to restart its count would let these through. For flutter removal, the bench sends a same-line reversal and checks that it is withheld and later released one edge after the other line moves. A design that drops the level for good, or releases it in the same edge as the other line, fails this check. Alternating traffic and reversals with removal off confirm that the stage leaves legal motion untouched.

// File: rtl/quad_glitch_filter.sv
module quad_glitch_filter #(
  parameter int LEN_W    = 3,
  parameter int BASE_LEN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s0_raw,
  input  logic             s1_raw,
  input  logic             filt_en,
  input  logic [LEN_W-1:0] len_code,
  input  logic             flutter_en,
  output logic             s0_out,
  output logic             s1_out
);
  localparam int MAX_LEN = (1 << LEN_W) - 1 + BASE_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [1:0] NO_MOVER = 2'd2;

  logic [1:0] raw, meta, sync, acc, out_q, mv;
  logic [1:0] last;
  logic [CNT_W-1:0] limit;

  assign raw   = {s1_raw, s0_raw};
  assign limit = CNT_W'(len_code) + CNT_W'(BASE_LEN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
    end else begin
      meta <= raw;
      sync <= meta;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    logic             level;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt   <= '0;
        level <= 1'b0;
      end else if (!filt_en) begin
        cnt   <= '0;
        level <= sync[i];
      end else if (sync[i] == level) begin
        cnt <= '0;
      end else if (cnt == limit) begin
        cnt   <= '0;
        level <= sync[i];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

    assign acc[i] = level;
    assign mv[i]  = (acc[i] ^ out_q[i]) & (!flutter_en || last != 2'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      last  <= NO_MOVER;
    end else begin
      out_q <= out_q ^ mv;
      case (mv)
        2'b01:   last <= 2'd0;
        2'b10:   last <= 2'd1;
        2'b11:   last <= NO_MOVER;
        default: last <= last;
      endcase
    end
  end

  assign s0_out = out_q[0];
  assign s1_out = out_q[1];
endmodule

// File: rtl/quad_glitch_filter_chk.sv
module quad_glitch_filter_chk #(
  parameter int LEN_W    = 3,
  parameter int BASE_LEN = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s0_raw,
  input logic             s1_raw,
  input logic             filt_en,
  input logic [LEN_W-1:0] len_code,
  input logic             flutter_en,
  input logic             s0_out,
  input logic             s1_out
);
  localparam int SAT = 63;

  int unsigned age, cfg_run, run0, run1;
  logic        pr0, pr1, po0, po1;
  logic [LEN_W-1:0] prev_len;
  logic [1:0]  last_ck;
  int unsigned win;

  assign win = int'(len_code) + BASE_LEN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= 0; cfg_run <= 0; run0 <= 0; run1 <= 0;
      pr0 <= 1'b0; pr1 <= 1'b0; po0 <= 1'b0; po1 <= 1'b0;
      prev_len <= '0; last_ck <= 2'd2;
    end else begin
      if (age < SAT) age <= age + 1;
      prev_len <= len_code;
      if (filt_en && !flutter_en && len_code == prev_len)
        cfg_run <= (cfg_run < SAT) ? cfg_run + 1 : cfg_run;
      else
        cfg_run <= 0;
      pr0 <= s0_raw;
      pr1 <= s1_raw;
      run0 <= (s0_raw == pr0) ? ((run0 < SAT) ? run0 + 1 : run0) : 1;
      run1 <= (s1_raw == pr1) ? ((run1 < SAT) ? run1 + 1 : run1) : 1;
      po0 <= s0_out;
      po1 <= s1_out;
      if (s0_out != po0 && s1_out == po1)      last_ck <= 2'd0;
      else if (s1_out != po1 && s0_out == po0) last_ck <= 2'd1;
      else if (s1_out != po1 && s0_out != po0) last_ck <= 2'd2;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!s0_out && !s1_out));

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 6 && !$past(filt_en, 2) && !$past(flutter_en))
    |-> (s0_out == $past(s0_raw, 4) && s1_out == $past(s1_raw, 4)));

  p_window_s0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 30 && cfg_run >= 20 && s0_out != po0)
    |-> ($past(run0, 3) >= win && s0_out == $past(s0_raw, 4)));

  p_window_s1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 30 && cfg_run >= 20 && s1_out != po1)
    |-> ($past(run1, 3) >= win && s1_out == $past(s1_raw, 4)));

  p_flutter_s0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2 && s0_out != po0 && $past(flutter_en)) |-> last_ck != 2'd0);

  p_flutter_s1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2 && s1_out != po1 && $past(flutter_en)) |-> last_ck != 2'd1);
endmodule

bind quad_glitch_filter quad_glitch_filter_chk #(.LEN_W(LEN_W), .BASE_LEN(BASE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .s0_raw(s0_raw), .s1_raw(s1_raw),
  .filt_en(filt_en), .len_code(len_code), .flutter_en(flutter_en),
  .s0_out(s0_out), .s1_out(s1_out)
);

// File: tb/quad_glitch_filter_bench.sv
module quad_glitch_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 3;

  typedef struct {
    int    at;
    logic  v0;
    logic  v1;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s0_raw = 1'b0, s1_raw = 1'b0, filt_en = 1'b0, flutter_en = 1'b0;
  logic [LEN_W-1:0] len_code = '0;
  logic s0_out, s1_out;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];

  quad_glitch_filter #(.LEN_W(LEN_W)) u_quad_glitch_filter (
    .clk(clk), .rst_n(rst_n), .s0_raw(s0_raw), .s1_raw(s1_raw),
    .filt_en(filt_en), .len_code(len_code), .flutter_en(flutter_en),
    .s0_out(s0_out), .s1_out(s1_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic e0, logic e1);
    checks++;
    if (s0_out !== e0 || s1_out !== e1) begin
      errors++;
      $display("FAIL %s at cycle %0d: got s0=%b s1=%b expected s0=%b s1=%b",
               tag, cyc, s0_out, s1_out, e0, e1);
    end
  endtask

  task automatic expect_at(int d, logic e0, logic e1, string tag);
    exp_t e;
    e.at = cyc + d; e.v0 = e0; e.v1 = e1; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        chk(q[i].tag, q[i].v0, q[i].v1);
        q.delete(i);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got run still active, expected completion");
    finish_run();
  end

  initial begin
    step(3);
    chk("R1 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    step(6);

    // R2: filter off
    s0_raw = 1'b1; expect_at(3, 0, 0, "R2 early"); expect_at(4, 1, 0, "R2 s0 rise"); step(8);
    s1_raw = 1'b1; expect_at(3, 1, 0, "R2 early"); expect_at(4, 1, 1, "R2 s1 rise"); step(8);
    s1_raw = 1'b0; expect_at(4, 1, 0, "R2 s1 fall"); step(8);
    s0_raw = 1'b0; expect_at(4, 0, 0, "R2 s0 fall"); step(8);

    // R3/R6: window lengths 5 and 12
    filt_en = 1'b1; len_code = 3'd0; step(4);
    s0_raw = 1'b1; expect_at(7, 0, 0, "R3 R6 code0 early"); expect_at(8, 1, 0, "R3 R6 code0 accept"); step(12);
    len_code = 3'd7; step(2);
    s0_raw = 1'b0; expect_at(14, 1, 0, "R3 R6 code7 early"); expect_at(15, 0, 0, "R3 R6 code7 accept"); step(20);

    // R4: excursions one sample short, both windows
    for (int c = 0; c < 2; c++) begin
      int l;
      len_code = (c == 0) ? 3'd0 : 3'd7;
      l = int'(len_code) + 5;
      step(2);
      s0_raw = 1'b1;
      expect_at(l + 3, 0, 0, "R4 short pulse");
      expect_at(l + 8, 0, 0, "R4 short pulse");
      step(l - 1);
      s0_raw = 1'b0;
      step(l + 12);
    end

    // R5: restart on one-sample return, code 0
    len_code = 3'd0; step(2);
    s0_raw = 1'b1; step(4); s0_raw = 1'b0; step(1); s0_raw = 1'b1;
    expect_at(6, 0, 0, "R5 restart"); expect_at(9, 0, 0, "R5 restart");
    step(4); s0_raw = 1'b0; step(15);

    // R7/R8: flutter removal
    filt_en = 1'b0; step(4);
    flutter_en = 1'b1; step(2);
    s1_raw = 1'b1; expect_at(4, 0, 1, "R7 s1 passes"); step(8);
    s0_raw = 1'b1; expect_at(4, 1, 1, "R7 s0 passes"); step(8);
    s0_raw = 1'b0;
    expect_at(4, 1, 1, "R7 reversal held"); expect_at(6, 1, 1, "R7 reversal held");
    expect_at(9, 1, 1, "R7 reversal held"); step(10);
    s1_raw = 1'b0; expect_at(4, 1, 0, "R8 other moves first"); expect_at(5, 0, 0, "R8 held level released"); step(8);

    // R9: alternating traffic with removal on
    s1_raw = 1'b1; expect_at(4, 0, 1, "R9 alt"); step(6);
    s0_raw = 1'b1; expect_at(4, 1, 1, "R9 alt"); step(6);
    s1_raw = 1'b0; expect_at(4, 1, 0, "R9 alt"); step(6);
    s0_raw = 1'b0; expect_at(4, 0, 0, "R9 alt"); step(8);

    // R10: removal off, reversals propagate
    flutter_en = 1'b0; step(2);
    s0_raw = 1'b1; expect_at(4, 1, 0, "R10 reversal passes"); step(6);
    s0_raw = 1'b0; expect_at(4, 0, 0, "R10 reversal passes"); step(8);

    while (q.size() != 0) step(1);
    step(2);
    finish_run();
  end
endmodule